// File: doc/BRIEF.md
# Receive FIFO Idle Timeout Flag

This block sits beside a serial receiver and its receive FIFO. When a few characters have landed in the FIFO but not enough to reach the programmed trigger level, the normal threshold interrupt never fires, and those characters could sit unnoticed. The block closes that gap. After each received stop bit it counts elementary time unit (etu) ticks. If no new start bit appears within 15 etu, and the FIFO holds at least one entry but fewer than the trigger level, it raises a data-ready flag. For an 8-data-bit, 1-stop-bit frame, 15 etu is one and a half frames.

Software clears the flag with a handshake. It must first read the flag while it is 1, and then write 0. A write of 1 is ignored, and so is a write of 0 that was not preceded by such a read. A standby request clears both the flag and the handshake marker, and so does reset. The flag, gated by an enable input, also drives an interrupt request.

Top module: `rx_idle_flag`

## Requirements
- R1: After a stop-end pulse, the flag rises on the edge of the 15th etu tick, provided no start pulse and no further stop-end pulse come in between. It is still 0 after the 14th tick. A new stop-end pulse restarts the count.
- R2: The flag never sets while the FIFO count is 0.
- R3: The flag never sets while the FIFO count is greater than or equal to the trigger level.
- R4: A start pulse before the 15th tick cancels the pending timeout for that idle period.
- R5: A flag write with data 1 never changes the flag.
- R6: A flag write with data 0 clears the flag only if the flag was read as 1 since the last clear, reset or standby. Otherwise it has no effect.
- R7: A read of 1 followed by a write of 0 clears the flag on the edge of the write.
- R8: If the timeout sets the flag in the same cycle as a valid clearing write, the flag stays 1.
- R9: Standby clears the flag and the read marker on the next edge, and also cancels any pending timeout.
- R10: The flag and the interrupt request are 0 after reset.
- R11: The timeout fires once per idle period. After a clear, further ticks do not set the flag again until another stop-end pulse.
- R12: irq equals the flag ANDed with irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| etu_tick | input | 1 | One-cycle pulse per elementary time unit |
| stop_end | input | 1 | Pulse at the end of a received stop bit |
| start_det | input | 1 | Pulse when a new start bit is detected |
| fifo_count | input | $clog2(DEPTH+1) | Receive FIFO occupancy |
| trig_level | input | $clog2(DEPTH+1) | Programmed receive trigger count |
| standby | input | 1 | Standby entry request |
| flag_rd | input | 1 | Read strobe for the flag |
| flag_wr | input | 1 | Write strobe for the flag |
| flag_wdata | input | 1 | Data written to the flag |
| irq_en | input | 1 | Interrupt enable |
| ready_flag | output | 1 | Data-ready flag |
| irq | output | 1 | Interrupt request |

## Verification
The timeout setting the flag and a valid clearing write can land in the same cycle. The bench provokes this by setting the flag and reading it as 1, so the handshake marker is armed. It then sends a fresh stop-end pulse and 14 ticks, and places the write of 0 on the cycle of the 15th tick. The flag must still be 1 afterwards. The same clear issued a cycle later, once the marker has been spent, must also leave the flag at 1, which shows the marker was consumed.

// File: rtl/rx_idle_flag.sv
module rx_idle_flag #(
  parameter int DEPTH       = 16,
  parameter int TIMEOUT_ETU = 15,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(TIMEOUT_ETU + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          etu_tick,
  input  logic          stop_end,
  input  logic          start_det,
  input  logic [CW-1:0] fifo_count,
  input  logic [CW-1:0] trig_level,
  input  logic          standby,
  input  logic          flag_rd,
  input  logic          flag_wr,
  input  logic          flag_wdata,
  input  logic          irq_en,
  output logic          ready_flag,
  output logic          irq
);

  logic          armed;
  logic [TW-1:0] etu_cnt;
  logic          rd_one;

  wire fire     = armed & etu_tick & (etu_cnt == TW'(TIMEOUT_ETU - 1));
  wire below    = (fifo_count != '0) && (fifo_count < trig_level);
  wire set_flag = fire & below;
  wire clr_ok   = flag_wr & ~flag_wdata & rd_one;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                armed <= 1'b0;
    else if (standby)          armed <= 1'b0;
    else if (stop_end)         armed <= 1'b1;
    else if (start_det | fire) armed <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  etu_cnt <= '0;
    else if (standby | stop_end) etu_cnt <= '0;
    else if (armed & etu_tick)   etu_cnt <= etu_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ready_flag <= 1'b0;
    else if (standby)  ready_flag <= 1'b0;
    else if (set_flag) ready_flag <= 1'b1;
    else if (clr_ok)   ready_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       rd_one <= 1'b0;
    else if (standby | clr_ok)        rd_one <= 1'b0;
    else if (flag_rd & ready_flag)    rd_one <= 1'b1;

  assign irq = ready_flag & irq_en;

endmodule

module rx_idle_flag_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          etu_tick,
  input logic          standby,
  input logic [CW-1:0] fifo_count,
  input logic [CW-1:0] trig_level,
  input logic          flag_wr,
  input logic          flag_wdata,
  input logic          rd_one,
  input logic          ready_flag
);

  // R2
  empty_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_flag) |-> $past(fifo_count) != '0);

  // R3
  below_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_flag) |-> $past(fifo_count) < $past(trig_level));

  // R1
  set_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_flag) |-> $past(etu_tick) && !$past(standby));

  // R9
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !ready_flag && !rd_one);

  // R5
  write_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_flag && flag_wr && flag_wdata && !standby |=> ready_flag);

  // R6
  no_read_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_flag && !rd_one && !standby |=> ready_flag);

  // R7
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_flag) |-> $past(standby) || ($past(flag_wr) && !$past(flag_wdata)));

endmodule

bind rx_idle_flag rx_idle_flag_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .standby(standby),
  .fifo_count(fifo_count), .trig_level(trig_level), .flag_wr(flag_wr),
  .flag_wdata(flag_wdata), .rd_one(rd_one), .ready_flag(ready_flag)
);

// File: tb/rx_idle_flag_tb.sv
module rx_idle_flag_tb_top;
  localparam int DEPTH = 16;
  localparam int TO    = 15;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic etu_tick = 0, stop_end = 0, start_det = 0, standby = 0;
  logic flag_rd = 0, flag_wr = 0, flag_wdata = 0, irq_en = 0;
  logic [CW-1:0] fifo_count = '0, trig_level = '0;
  logic ready_flag, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_idle_flag #(.DEPTH(DEPTH), .TIMEOUT_ETU(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .stop_end(stop_end),
    .start_det(start_det), .fifo_count(fifo_count), .trig_level(trig_level),
    .standby(standby), .flag_rd(flag_rd), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .irq_en(irq_en), .ready_flag(ready_flag), .irq(irq));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      etu_tick = 1; step(); etu_tick = 0; step();
    end
  endtask

  task automatic stop_pulse();
    stop_end = 1; step(); stop_end = 0;
  endtask

  task automatic sby();
    standby = 1; step(); standby = 0;
  endtask

  task automatic rd();
    flag_rd = 1; step(); flag_rd = 0;
  endtask

  task automatic wr(input logic d);
    flag_wr = 1; flag_wdata = d; step(); flag_wr = 0; flag_wdata = 0;
  endtask

  task automatic make_set();
    sby(); fifo_count = 2; trig_level = 8;
    stop_pulse(); ticks(TO);
  endtask

  initial begin
    step(); step();
    check(ready_flag, 1'b0, "R10 flag in reset");
    check(irq, 1'b0, "R10 irq in reset");
    rst_n = 1; step();

    for (int t = 1; t <= DEPTH; t++)
      for (int c = 0; c <= DEPTH; c++) begin
        logic exp;
        exp = (c >= 1) && (c < t);
        sby();
        trig_level = CW'(t); fifo_count = CW'(c); irq_en = c[0];
        stop_pulse(); ticks(TO - 1);
        check(ready_flag, 1'b0, "R1 before 15th tick");
        ticks(1);
        check(ready_flag, exp, c == 0 ? "R2 empty fifo" : (c >= t ? "R3 at/above trigger" : "R1 timeout set"));
        check(irq, exp & irq_en, "R12 irq gating");
        ticks(3);
        check(ready_flag, exp, "R11 stays after fire");
      end

    sby(); fifo_count = 3; trig_level = 8;
    stop_pulse(); ticks(10); start_det = 1; step(); start_det = 0; ticks(10);
    check(ready_flag, 1'b0, "R4 start cancels timeout");

    sby(); stop_pulse(); ticks(10); stop_pulse(); ticks(TO - 1);
    check(ready_flag, 1'b0, "R1 restart on stop");
    ticks(1);
    check(ready_flag, 1'b1, "R1 restart then set");

    make_set(); rd(); wr(1'b1);
    check(ready_flag, 1'b1, "R5 write one ignored");
    make_set(); wr(1'b0);
    check(ready_flag, 1'b0 ^ 1'b1, "R6 clear without read ignored");
    rd(); wr(1'b0);
    check(ready_flag, 1'b0, "R7 read then clear");
    ticks(TO + 2);
    check(ready_flag, 1'b0, "R11 no refire after clear");

    make_set(); rd(); stop_pulse(); ticks(TO - 1);
    etu_tick = 1; flag_wr = 1; flag_wdata = 0; step();
    etu_tick = 0; flag_wr = 0;
    check(ready_flag, 1'b1, "R8 set wins over clear");
    wr(1'b0);
    check(ready_flag, 1'b1, "R8 marker consumed");

    make_set(); rd(); sby();
    check(ready_flag, 1'b0, "R9 standby clears flag");
    fifo_count = 2; trig_level = 8; stop_pulse(); ticks(TO); wr(1'b0);
    check(ready_flag, 1'b1, "R9 standby clears marker");
    sby(); stop_pulse(); ticks(5); sby(); ticks(TO);
    check(ready_flag, 1'b0, "R9 standby cancels timeout");

    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 150000) begin @(posedge clk); n++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule